// File: doc/BRIEF.md
# Type-1 Bridge Configuration Register Block

This block holds the bridge-only registers of a type-1 configuration header: the primary, secondary and subordinate bus numbers, the secondary latency timer, the I/O, memory and prefetchable base/limit windows with their upper extensions, and the bridge control word. A configuration agent writes to them one dword at a time with per-byte enables and reads them back through a combinational read port. The few fixed identity fields that make the function show up as a bridge (class code, header type, both status words) are returned on the same read port.

Two event pulses come out of the write path. One tells the window decoder downstream that a window register was written and its mappings must be rebuilt. The other asks for a hot reset of the secondary bus when software sets the bus-reset bit in bridge control. The window decoder also gets the decoded base and limit addresses of all three windows all the time, together with the secondary and subordinate bus numbers.

A separate one-cycle park command puts every window into a state where base is above limit, so that nothing is forwarded until software sets the windows up again.

Top module: `brcfg_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the bus numbers, latency timer, every base/limit range field, both prefetchable upper-32 registers, both I/O upper-16 registers and bridge control are cleared. After reset, dword 6 reads 0, dword 7 reads 0x00A0_0101, dword 9 reads 0x0001_0001, and dwords 8, 10, 11, 12 and 15 read 0 (default parameters).
- R2: Fixed reads: dword 1 returns 0x00A0_0000 (66 MHz and fast back-to-back status bits 5 and 7). Dword 2 returns 0x0604_0000 (bridge class). Dword 3 returns header type `{mf_bit, 7'h01}` in bits 23:16, with all other bits 0. Bits 31:16 of dword 7 return secondary status 0x00A0.
- R3: A write to dword 6, 10, 11 or 12 updates each byte whose enable is set. In dword 7 only bits 7:4 and 15:12 are writable, and bits 3:0 and 11:8 read 1 (32-bit I/O). In dwords 8 and 9 only bits 15:4 and 31:20 are writable. Bits 3:0 and 19:16 read 0 in dword 8 and 1 in dword 9 (64-bit prefetchable). In dword 15 only bits 27:16 are writable. Writes to other dwords change nothing.
- R4: An accepted write whose enabled bytes touch byte address 0x1C or 0x1D (byte address = dword*4 + lane) raises `remap_pulse` for exactly the following cycle.
- R5: An accepted write touching any byte from 0x20 through 0x33 raises `remap_pulse` the following cycle. A write touching neither span leaves it low.
- R6: `sec_rst_pulse` is high for one cycle after an accepted write to dword 15 with lane 2 enabled that takes bridge-control bit 6 (data bit 22) from 0 to 1. Writing 1 over 1, writing 0, or leaving lane 2 disabled gives no pulse.
- R7: A `park` cycle sets every base range field to all ones and clears every limit range field. It zeroes both prefetchable upper-32 registers, leaves the I/O upper registers alone, raises `remap_pulse` the next cycle, and causes a write in the same cycle to be ignored.
- R8: Window outputs: `io_base = {io_upper_base, iob[7:4], 12'h000}` and `io_limit = {io_upper_limit, iol[7:4], 12'hFFF}`. `mem_base = {mem_base[15:4], 20'h0}` and `mem_limit = {mem_limit[15:4], 20'hFFFFF}`. The prefetchable outputs are built the same way, with the upper-32 registers as bits 63:32.
- R9: Reset has priority over park and writes. The cycle after a reset edge, both pulses are low, even if a write or park was presented during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_dw | input | 6 | Dword index of the write within the 256-byte header |
| wr_be | input | 4 | Byte enables, lane 0 = bits 7:0 |
| wr_data | input | 32 | Write data |
| park | input | 1 | Disable-forwarding command, one cycle |
| mf_bit | input | 1 | Multi-function bit reflected in the header type |
| rd_dw | input | 6 | Dword index to read |
| rd_data | output | 32 | Combinational read data |
| remap_pulse | output | 1 | Window registers written or parked |
| sec_rst_pulse | output | 1 | Secondary-bus hot reset request |
| sec_bus | output | 8 | Secondary bus number |
| sub_bus | output | 8 | Subordinate bus number |
| io_base | output | 32 | Decoded I/O window base |
| io_limit | output | 32 | Decoded I/O window limit |
| mem_base | output | 32 | Decoded memory window base |
| mem_limit | output | 32 | Decoded memory window limit |
| pf_base | output | 64 | Decoded prefetchable window base |
| pf_limit | output | 64 | Decoded prefetchable window limit |

## Verification
The bench builds the block with both upper extensions on (`IO32 = 1`, `PF64 = 1`). This puts the 32-bit I/O and 64-bit prefetchable window arithmetic and the read-only type nibbles that report them within reach. With this configuration, the whole write address space is small enough to sweep every dword index against every one of the 16 byte-enable patterns. Remap and hot-reset expectations are computed from byte addresses and from a one-bit model of the bus-reset bit.

// File: rtl/brcfg_pkg.sv
package brcfg_pkg;

    localparam int DATA_W  = 32;
    localparam int DWIX_W  = 6;
    localparam int LANES   = DATA_W / 8;

    localparam logic [DWIX_W-1:0] DW_CMDSTAT = 6'd1;
    localparam logic [DWIX_W-1:0] DW_CLASS   = 6'd2;
    localparam logic [DWIX_W-1:0] DW_HDR     = 6'd3;
    localparam logic [DWIX_W-1:0] DW_BUSNUM  = 6'd6;
    localparam logic [DWIX_W-1:0] DW_IOWIN   = 6'd7;
    localparam logic [DWIX_W-1:0] DW_MEMWIN  = 6'd8;
    localparam logic [DWIX_W-1:0] DW_PFWIN   = 6'd9;
    localparam logic [DWIX_W-1:0] DW_PFBUP   = 6'd10;
    localparam logic [DWIX_W-1:0] DW_PFLUP   = 6'd11;
    localparam logic [DWIX_W-1:0] DW_IOUP    = 6'd12;
    localparam logic [DWIX_W-1:0] DW_BCTL    = 6'd15;

    localparam logic [7:0] IO_SPAN_LO  = 8'h1C;
    localparam logic [7:0] IO_SPAN_HI  = 8'h1D;
    localparam logic [7:0] WIN_SPAN_LO = 8'h20;
    localparam logic [7:0] WIN_SPAN_HI = 8'h33;

    localparam int          BUSRST_BIT = 6;
    localparam logic [15:0] BCTL_WMASK = 16'h0FFF;
    localparam logic [15:0] STAT_CAPS  = 16'h00A0;
    localparam logic [23:0] CLASS_P2P  = 24'h060400;
    localparam logic [6:0]  HDR_TYPE1  = 7'h01;

    typedef struct packed {
        logic [7:0]  pri;
        logic [7:0]  sec;
        logic [7:0]  sub;
        logic [7:0]  lat;
        logic [3:0]  io_b;
        logic [3:0]  io_l;
        logic [11:0] mem_b;
        logic [11:0] mem_l;
        logic [11:0] pf_b;
        logic [11:0] pf_l;
        logic [31:0] pf_bu;
        logic [31:0] pf_lu;
        logic [15:0] io_bu;
        logic [15:0] io_lu;
        logic [15:0] bctl;
    } brregs_t;

    typedef struct packed {
        logic [31:0] io_base;
        logic [31:0] io_limit;
        logic [31:0] mem_base;
        logic [31:0] mem_limit;
        logic [63:0] pf_base;
        logic [63:0] pf_limit;
    } brwin_t;

    function automatic logic in_span(input logic [7:0] a,
                                     input logic [7:0] lo,
                                     input logic [7:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic touches_window(input logic [DWIX_W-1:0] dw,
                                            input logic [LANES-1:0]  be);
        logic hit;
        logic [7:0] a;
        hit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            a = {dw, 2'b00} + 8'(i);
            if (be[i] && (in_span(a, IO_SPAN_LO, IO_SPAN_HI) ||
                          in_span(a, WIN_SPAN_LO, WIN_SPAN_HI)))
                hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/brcfg_store.sv
module brcfg_store
    import brcfg_pkg::*;
#(
    parameter bit IO32 = 1'b1,
    parameter bit PF64 = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                park,
    input  logic                wr_go,
    input  logic [DWIX_W-1:0]   wr_dw,
    input  logic [LANES-1:0]    wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    output brregs_t             regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (park) begin
            regs.io_b  <= '1;
            regs.io_l  <= '0;
            regs.mem_b <= '1;
            regs.mem_l <= '0;
            regs.pf_b  <= '1;
            regs.pf_l  <= '0;
            regs.pf_bu <= '0;
            regs.pf_lu <= '0;
        end else if (wr_go) begin
            case (wr_dw)
                DW_BUSNUM: begin
                    if (wr_be[0]) regs.pri <= wr_data[7:0];
                    if (wr_be[1]) regs.sec <= wr_data[15:8];
                    if (wr_be[2]) regs.sub <= wr_data[23:16];
                    if (wr_be[3]) regs.lat <= wr_data[31:24];
                end
                DW_IOWIN: begin
                    if (wr_be[0]) regs.io_b <= wr_data[7:4];
                    if (wr_be[1]) regs.io_l <= wr_data[15:12];
                end
                DW_MEMWIN: begin
                    if (wr_be[0]) regs.mem_b[3:0]  <= wr_data[7:4];
                    if (wr_be[1]) regs.mem_b[11:4] <= wr_data[15:8];
                    if (wr_be[2]) regs.mem_l[3:0]  <= wr_data[23:20];
                    if (wr_be[3]) regs.mem_l[11:4] <= wr_data[31:24];
                end
                DW_PFWIN: begin
                    if (wr_be[0]) regs.pf_b[3:0]  <= wr_data[7:4];
                    if (wr_be[1]) regs.pf_b[11:4] <= wr_data[15:8];
                    if (wr_be[2]) regs.pf_l[3:0]  <= wr_data[23:20];
                    if (wr_be[3]) regs.pf_l[11:4] <= wr_data[31:24];
                end
                DW_PFBUP: begin
                    if (PF64) begin
                        for (int i = 0; i < LANES; i++)
                            if (wr_be[i]) regs.pf_bu[8*i +: 8] <= wr_data[8*i +: 8];
                    end
                end
                DW_PFLUP: begin
                    if (PF64) begin
                        for (int i = 0; i < LANES; i++)
                            if (wr_be[i]) regs.pf_lu[8*i +: 8] <= wr_data[8*i +: 8];
                    end
                end
                DW_IOUP: begin
                    if (IO32) begin
                        if (wr_be[0]) regs.io_bu[7:0]  <= wr_data[7:0];
                        if (wr_be[1]) regs.io_bu[15:8] <= wr_data[15:8];
                        if (wr_be[2]) regs.io_lu[7:0]  <= wr_data[23:16];
                        if (wr_be[3]) regs.io_lu[15:8] <= wr_data[31:24];
                    end
                end
                DW_BCTL: begin
                    if (wr_be[2]) regs.bctl[7:0]  <= wr_data[23:16] & BCTL_WMASK[7:0];
                    if (wr_be[3]) regs.bctl[15:8] <= wr_data[31:24] & BCTL_WMASK[15:8];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/brcfg_event.sv
module brcfg_event
    import brcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              park,
    input  logic              wr_go,
    input  logic [DWIX_W-1:0] wr_dw,
    input  logic [LANES-1:0]  wr_be,
    input  logic              wr_rst_bit,
    input  logic              bus_rst_q,
    output logic              remap_pulse,
    output logic              sec_rst_pulse
);

    logic bctl_lane_hit;
    assign bctl_lane_hit = wr_go && (wr_dw == DW_BCTL) && wr_be[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            remap_pulse   <= 1'b0;
            sec_rst_pulse <= 1'b0;
        end else begin
            remap_pulse   <= park || (wr_go && touches_window(wr_dw, wr_be));
            sec_rst_pulse <= bctl_lane_hit && wr_rst_bit && !bus_rst_q;
        end
    end

endmodule

// File: rtl/brcfg_view.sv
module brcfg_view
    import brcfg_pkg::*;
#(
    parameter bit IO32 = 1'b1,
    parameter bit PF64 = 1'b1
) (
    input  brregs_t            regs,
    input  logic               mf_bit,
    input  logic [DWIX_W-1:0]  rd_dw,
    output logic [DATA_W-1:0]  rd_data,
    output brwin_t             win
);

    localparam logic [3:0] IO_TYPE = IO32 ? 4'h1 : 4'h0;
    localparam logic [3:0] PF_TYPE = PF64 ? 4'h1 : 4'h0;

    logic [15:0] io_hi_b, io_hi_l;
    logic [31:0] pf_hi_b, pf_hi_l;

    generate
        if (IO32) begin : g_io32
            assign io_hi_b = regs.io_bu;
            assign io_hi_l = regs.io_lu;
        end else begin : g_io16
            assign io_hi_b = '0;
            assign io_hi_l = '0;
        end
        if (PF64) begin : g_pf64
            assign pf_hi_b = regs.pf_bu;
            assign pf_hi_l = regs.pf_lu;
        end else begin : g_pf32
            assign pf_hi_b = '0;
            assign pf_hi_l = '0;
        end
    endgenerate

    always_comb begin
        win.io_base   = {io_hi_b, regs.io_b, 12'h000};
        win.io_limit  = {io_hi_l, regs.io_l, 12'hFFF};
        win.mem_base  = {regs.mem_b, 20'h00000};
        win.mem_limit = {regs.mem_l, 20'hFFFFF};
        win.pf_base   = {pf_hi_b, regs.pf_b, 20'h00000};
        win.pf_limit  = {pf_hi_l, regs.pf_l, 20'hFFFFF};
    end

    always_comb begin
        case (rd_dw)
            DW_CMDSTAT: rd_data = {STAT_CAPS, 16'h0000};
            DW_CLASS:   rd_data = {CLASS_P2P, 8'h00};
            DW_HDR:     rd_data = {8'h00, mf_bit, HDR_TYPE1, 16'h0000};
            DW_BUSNUM:  rd_data = {regs.lat, regs.sub, regs.sec, regs.pri};
            DW_IOWIN:   rd_data = {STAT_CAPS, regs.io_l, IO_TYPE, regs.io_b, IO_TYPE};
            DW_MEMWIN:  rd_data = {regs.mem_l, 4'h0, regs.mem_b, 4'h0};
            DW_PFWIN:   rd_data = {regs.pf_l, PF_TYPE, regs.pf_b, PF_TYPE};
            DW_PFBUP:   rd_data = pf_hi_b;
            DW_PFLUP:   rd_data = pf_hi_l;
            DW_IOUP:    rd_data = {io_hi_l, io_hi_b};
            DW_BCTL:    rd_data = {regs.bctl, 16'h0000};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/brcfg_regs.sv
module brcfg_regs
    import brcfg_pkg::*;
#(
    parameter bit IO32 = 1'b1,
    parameter bit PF64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  wr_dw,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        park,
    input  logic        mf_bit,
    input  logic [5:0]  rd_dw,
    output logic [31:0] rd_data,
    output logic        remap_pulse,
    output logic        sec_rst_pulse,
    output logic [7:0]  sec_bus,
    output logic [7:0]  sub_bus,
    output logic [31:0] io_base,
    output logic [31:0] io_limit,
    output logic [31:0] mem_base,
    output logic [31:0] mem_limit,
    output logic [63:0] pf_base,
    output logic [63:0] pf_limit
);

    brregs_t regs_q;
    brwin_t  win;
    logic    wr_go;
    logic    bus_rst_q;

    assign wr_go     = wr_en && !park;
    assign bus_rst_q = regs_q.bctl[BUSRST_BIT];

    brcfg_store #(.IO32(IO32), .PF64(PF64)) u_store (
        .clk     (clk),
        .rst     (rst),
        .park    (park),
        .wr_go   (wr_go),
        .wr_dw   (wr_dw),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .regs    (regs_q)
    );

    brcfg_event u_event (
        .clk           (clk),
        .rst           (rst),
        .park          (park),
        .wr_go         (wr_go),
        .wr_dw         (wr_dw),
        .wr_be         (wr_be),
        .wr_rst_bit    (wr_data[16+BUSRST_BIT]),
        .bus_rst_q     (bus_rst_q),
        .remap_pulse   (remap_pulse),
        .sec_rst_pulse (sec_rst_pulse)
    );

    brcfg_view #(.IO32(IO32), .PF64(PF64)) u_view (
        .regs    (regs_q),
        .mf_bit  (mf_bit),
        .rd_dw   (rd_dw),
        .rd_data (rd_data),
        .win     (win)
    );

    assign sec_bus   = regs_q.sec;
    assign sub_bus   = regs_q.sub;
    assign io_base   = win.io_base;
    assign io_limit  = win.io_limit;
    assign mem_base  = win.mem_base;
    assign mem_limit = win.mem_limit;
    assign pf_base   = win.pf_base;
    assign pf_limit  = win.pf_limit;

endmodule

// File: rtl/brcfg_chk.sv
module brcfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        park,
    input logic        remap_pulse,
    input logic        sec_rst_pulse,
    input logic        bus_rst_bit,
    input logic [31:0] mem_base,
    input logic [31:0] mem_limit,
    input logic [63:0] pf_base,
    input logic [63:0] pf_limit
);

    // R9
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!remap_pulse && !sec_rst_pulse));

    // R4
    remap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        remap_pulse |-> $past(wr_en || park));

    // R6
    sec_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sec_rst_pulse |-> (bus_rst_bit && !$past(bus_rst_bit)));

    // R6
    rst_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bus_rst_bit));

    // R7
    park_order_chk: assert property (@(posedge clk) disable iff (rst)
        park |=> ((mem_base > mem_limit) && (pf_base > pf_limit)));

endmodule

bind brcfg_regs brcfg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .park          (park),
    .remap_pulse   (remap_pulse),
    .sec_rst_pulse (sec_rst_pulse),
    .bus_rst_bit   (bus_rst_q),
    .mem_base      (mem_base),
    .mem_limit     (mem_limit),
    .pf_base       (pf_base),
    .pf_limit      (pf_limit)
);

// File: tb/sim_brcfg_regs.sv
module sim_brcfg_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_dw = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        park = 1'b0;
    logic        mf_bit = 1'b1;
    logic [5:0]  rd_dw = '0;
    logic [31:0] rd_data;
    logic        remap_pulse, sec_rst_pulse;
    logic [7:0]  sec_bus, sub_bus;
    logic [31:0] io_base, io_limit, mem_base, mem_limit;
    logic [63:0] pf_base, pf_limit;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] dv [16];
    logic rbit;

    always #10 clk = ~clk;

    brcfg_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be),
        .wr_data(wr_data), .park(park), .mf_bit(mf_bit), .rd_dw(rd_dw),
        .rd_data(rd_data), .remap_pulse(remap_pulse), .sec_rst_pulse(sec_rst_pulse),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .io_base(io_base), .io_limit(io_limit),
        .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] dw, output logic [31:0] d);
        rd_dw = dw;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d,
                      output logic rm, output logic sr);
        @(negedge clk);
        wr_en = 1'b1; wr_dw = dw; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        rm = remap_pulse;
        sr = sec_rst_pulse;
    endtask

    function automatic logic exp_remap(input logic [5:0] dw, input logic [3:0] be);
        logic hit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            int a = dw * 4 + i;
            if (be[i] && ((a >= 28 && a <= 29) || (a >= 32 && a <= 51))) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] dw, input logic [31:0] d);
        case (dw)
            6'd6, 6'd10, 6'd11, 6'd12: return d;
            6'd7:  return {16'h00A0, d[15:12], 4'h1, d[7:4], 4'h1};
            6'd8:  return {d[31:20], 4'h0, d[15:4], 4'h0};
            6'd9:  return {d[31:20], 4'h1, d[15:4], 4'h1};
            6'd15: return {4'h0, d[27:16], 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic rm, sr;

        repeat (3) @(negedge clk);
        // R9: pulses quiet during reset
        chk("R9 remap in reset", remap_pulse, 0);
        chk("R9 secrst in reset", sec_rst_pulse, 0);
        rst = 1'b0;

        // R1: reset contents
        rd(6'd6, d);  chk("R1 bus dword", d, 32'h0);
        rd(6'd7, d);  chk("R1 io dword", d, 32'h00A0_0101);
        rd(6'd8, d);  chk("R1 mem dword", d, 32'h0);
        rd(6'd9, d);  chk("R1 pf dword", d, 32'h0001_0001);
        rd(6'd10, d); chk("R1 pf upper base", d, 32'h0);
        rd(6'd11, d); chk("R1 pf upper limit", d, 32'h0);
        rd(6'd12, d); chk("R1 io upper", d, 32'h0);
        rd(6'd15, d); chk("R1 bctl", d, 32'h0);

        // R2: identity fields
        rd(6'd1, d); chk("R2 status", d, 32'h00A0_0000);
        rd(6'd2, d); chk("R2 class", d, 32'h0604_0000);
        rd(6'd3, d); chk("R2 header mf=1", d, 32'h0081_0000);
        mf_bit = 1'b0;
        rd(6'd3, d); chk("R2 header mf=0", d, 32'h0001_0000);

        // R3: full-dword writes and readback; R4/R5 remap for each
        for (int k = 0; k < 16; k++) begin
            logic [31:0] pat;
            pat = (32'h9E37_79B9 * (k + 3)) & ~32'h0040_0000;
            dv[k] = pat;
            wr(6'(k), 4'hF, pat, rm, sr);
            chk("R4 R5 remap full write", rm, exp_remap(6'(k), 4'hF));
            if (k != 1 && k != 2 && k != 3) begin
                rd(6'(k), d);
                chk("R3 readback", d, exp_rd(6'(k), pat));
            end
        end
        chk("R3 sec_bus", sec_bus, dv[6][15:8]);
        chk("R3 sub_bus", sub_bus, dv[6][23:16]);

        // R3: partial lanes
        wr(6'd6, 4'b0010, 32'hFFFF_FFFF, rm, sr);
        rd(6'd6, d);
        chk("R3 lane1 only", d, {dv[6][31:16], 8'hFF, dv[6][7:0]});
        chk("R5 no remap bus write", rm, 0);
        dv[6][15:8] = 8'hFF;

        // R8: window outputs
        chk("R8 io_base",  io_base,  {dv[12][15:0], dv[7][7:4], 12'h000});
        chk("R8 io_limit", io_limit, {dv[12][31:16], dv[7][15:12], 12'hFFF});
        chk("R8 mem_base", mem_base, {dv[8][15:4], 20'h0});
        chk("R8 mem_limit", mem_limit, {dv[8][31:20], 20'hFFFFF});
        chk("R8 pf_base",  pf_base,  {dv[10], dv[9][15:4], 20'h0});
        chk("R8 pf_limit", pf_limit, {dv[11], dv[9][31:20], 20'hFFFFF});

        // R6: hot reset edge
        wr(6'd15, 4'b0100, 32'h0000_0000, rm, sr);
        chk("R6 clear bit", sr, 0);
        wr(6'd15, 4'b1011, 32'h0040_0000, rm, sr);
        chk("R6 lane2 disabled", sr, 0);
        wr(6'd15, 4'b0100, 32'h0040_0000, rm, sr);
        chk("R6 rising edge", sr, 1);
        @(negedge clk);
        chk("R6 single cycle", sec_rst_pulse, 0);
        wr(6'd15, 4'b0100, 32'h0040_0000, rm, sr);
        chk("R6 one over one", sr, 0);
        wr(6'd15, 4'b0100, 32'h0000_0000, rm, sr);
        chk("R6 falling", sr, 0);
        rbit = 1'b0;

        // R7: park with a concurrent write
        @(negedge clk);
        park = 1'b1; wr_en = 1'b1; wr_dw = 6'd6; wr_be = 4'hF; wr_data = 32'h1234_5678;
        @(negedge clk);
        park = 1'b0; wr_en = 1'b0; wr_be = '0;
        chk("R7 remap on park", remap_pulse, 1);
        rd(6'd6, d); chk("R7 write ignored", d, dv[6]);
        chk("R7 mem_base", mem_base, 32'hFFF0_0000);
        chk("R7 mem_limit", mem_limit, 32'h000F_FFFF);
        chk("R7 pf_base", pf_base, 64'h0000_0000_FFF0_0000);
        chk("R7 pf_limit", pf_limit, 64'h0000_0000_000F_FFFF);
        chk("R7 io_base", io_base, {dv[12][15:0], 4'hF, 12'h000});
        chk("R7 io_limit", io_limit, {dv[12][31:16], 4'h0, 12'hFFF});
        @(negedge clk);
        chk("R7 remap single", remap_pulse, 0);

        // R4 R5 R6: sweep every dword against every byte-enable pattern
        for (int dw = 0; dw < 64; dw++) begin
            for (int be = 0; be < 16; be++) begin
                logic [31:0] pat;
                logic nb, esr;
                pat = 32'h9E37_79B9 * (dw * 16 + be + 1);
                nb = rbit;
                if (dw == 15 && be[2]) nb = pat[22];
                esr = !rbit && nb;
                wr(6'(dw), 4'(be), pat, rm, sr);
                chk("R4 R5 remap sweep", rm, exp_remap(6'(dw), 4'(be)));
                chk("R6 secrst sweep", sr, esr);
                rbit = nb;
            end
        end

        // R9: reset priority over write and park
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_dw = 6'd7; wr_be = 4'hF; park = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; park = 1'b0; wr_be = '0;
        @(negedge clk);
        chk("R9 remap after reset", remap_pulse, 0);
        chk("R9 secrst after reset", sec_rst_pulse, 0);
        rst = 1'b0;
        rd(6'd8, d); chk("R1 mem cleared again", d, 32'h0);
        rd(6'd6, d); chk("R1 bus cleared again", d, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule